// File: doc/BRIEF.md
# Stride-Predicting Data Address Trace Compressor

This block shrinks a stream of data addresses produced by load and store instructions. Each incoming pair holds an instruction address and the data address it touched. The pair selects one slot of a direct-mapped table through a slice of the instruction address, and no tag is checked. Each slot keeps the previous data address seen there and a signed 8-bit stride. When the new address minus the remembered address equals the remembered stride, the block records a single 1 bit. Otherwise it records a 0 bit, sends the full address on a separate miss stream and learns the new stride.

The one-bit outcomes are packed least-significant-bit first into bytes on a byte stream. Each byte carries a count of the bits it holds: 8 for a full byte, or fewer when a flush pulse forces out a partial byte. Pairs enter through an internal FIFO. Both output streams use valid/ready handshakes and hold their word while stalled.

Control is a three-state machine. CLEAR zeroes one table slot per cycle after reset and moves to IDLE after the last slot (transition *sweep done*). IDLE serves a pending flush first (transition *flush*, stays in IDLE). Otherwise, when the FIFO holds a pair and both output registers are empty, IDLE pops the pair and issues the table read (transition *accept*, to COMPARE). COMPARE evaluates the stride, writes the slot back, appends the bit and loads the miss word on a mismatch, then returns (transition *retire*, to IDLE).

Top module: `stride_trace_compressor`

## Requirements
- R1: After reset both output valids are low and `in_ready` stays low while every table slot is cleared, one slot per cycle (1024 cycles). A slot never written since reset therefore behaves as last address 0 with stride 0.
- R2: The slot is selected by instruction address bits [11:2]. Instruction addresses that differ only outside those bits share one slot, with no tag check.
- R3: The candidate stride is the data address minus the slot's last address, modulo 2^32. When it equals the stored 8-bit stride sign-extended to 32 bits, the outcome bit is 1 and no miss word is produced.
- R4: When the candidate stride differs from the stored stride, the outcome bit is 0 and the full 32-bit data address is sent as one miss word.
- R5: On a mismatch the stored stride becomes bits [7:0] of the candidate stride. A stride outside -128..127 is therefore truncated and keeps missing.
- R6: Every access, hit or miss, overwrites the slot's last address with the incoming data address.
- R7: Outcome bits fill a byte from bit 0 upward in arrival order. A byte is released with count 8 as soon as its eighth bit arrives.
- R8: A `flush` pulse releases the bits accumulated so far as a byte, with the count equal to the number of bits held and the unused upper bits 0. With no bits held, a flush produces nothing. A flush raised in the same cycle a pair is accepted applies before that pair.
- R9: `in_ready` is low whenever `bt_ready` or `ms_ready` is low, whenever the FIFO is full and during the clear sweep. A stalled output holds its valid and data unchanged.
- R10: Pairs are taken without loss or reordering, including back-to-back pushes. Bytes and miss words appear in the order of the pairs that caused them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Pair offered |
| in_ready | output | 1 | Pair accepted when high together with `in_valid` |
| in_pc | input | 32 | Instruction address of the access |
| in_addr | input | 32 | Data address of the access |
| flush | input | 1 | Release the partially filled byte |
| bt_valid | output | 1 | Packed byte available |
| bt_ready | input | 1 | Byte consumer ready |
| bt_byte | output | 8 | Outcome bits, first outcome in bit 0 |
| bt_bits | output | 4 | Number of valid bits in `bt_byte` (1 to 8) |
| ms_valid | output | 1 | Miss word available |
| ms_ready | input | 1 | Miss consumer ready |
| ms_addr | output | 32 | Data address that missed |

## Verification
Two functions can fall close together: releasing a full byte on its eighth outcome bit, and serving a flush. The bench provokes both orderings. In one case it raises `flush` in the cycle the pair completing a byte is accepted, so the flush must take the seven held bits and the pair must begin a new byte. In the other it raises `flush` one cycle after that pair, while the pair is still in the pipeline, so the flush must find nothing left and add no byte. The behavioural model fixes which bits belong to which byte and count, and every released byte is compared against it on the clock it is taken.

// File: rtl/stc_pkg.sv
package stc_pkg;

    localparam int STC_PC_W       = 32;
    localparam int STC_ADDR_W     = 32;
    localparam int STC_IDX_W      = 10;
    localparam int STC_IDX_LSB    = 2;
    localparam int STC_STRIDE_W   = 8;
    localparam int STC_FIFO_DEPTH = 8;
    localparam int STC_BYTE_W     = 8;

    // control states of the compressor
    typedef enum logic [1:0] {
        ST_CLEAR   = 2'd0,
        ST_IDLE    = 2'd1,
        ST_COMPARE = 2'd2
    } stc_state_e;

endpackage

// File: rtl/stc_fifo.sv
module stc_fifo #(
    parameter int W     = 64,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push;
    logic             do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/stc_stride_table.sv
module stc_stride_table #(
    parameter int IDX_W   = 10,
    parameter int ENTRY_W = 40
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [ENTRY_W-1:0] wr_data,
    input  logic               rd_en,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [ENTRY_W-1:0] rd_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [ENTRY_W-1:0] slots [DEPTH];

    // synchronous read, one write port; control never issues both to the same cycle
    always_ff @(posedge clk) begin
        if (wr_en) begin
            slots[wr_idx] <= wr_data;
        end
        if (rd_en) begin
            rd_data <= slots[rd_idx];
        end
    end

endmodule

// File: rtl/stc_bit_packer.sv
module stc_bit_packer #(
    parameter int BYTE_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bit_en,
    input  logic                         bit_val,
    input  logic                         flush_en,
    input  logic                         out_ready,
    output logic                         out_valid,
    output logic [BYTE_W-1:0]            out_byte,
    output logic [$clog2(BYTE_W+1)-1:0]  out_bits
);
    localparam int CNT_W = $clog2(BYTE_W + 1);

    logic [BYTE_W-1:0] acc;
    logic [CNT_W-1:0]  held;
    logic [BYTE_W-1:0] acc_next;
    logic              last_bit;

    always_comb begin
        acc_next = acc;
        acc_next[held[$clog2(BYTE_W)-1:0]] = bit_val;
    end

    assign last_bit = (held == CNT_W'(BYTE_W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc       <= '0;
            held      <= '0;
            out_valid <= 1'b0;
            out_byte  <= '0;
            out_bits  <= '0;
        end else begin
            if (out_valid && out_ready) begin
                out_valid <= 1'b0;
            end
            if (bit_en) begin
                if (last_bit) begin
                    out_byte  <= acc_next;
                    out_bits  <= CNT_W'(BYTE_W);
                    out_valid <= 1'b1;
                    acc       <= '0;
                    held      <= '0;
                end else begin
                    acc  <= acc_next;
                    held <= held + 1'b1;
                end
            end else if (flush_en && (held != '0)) begin
                out_byte  <= acc;
                out_bits  <= held;
                out_valid <= 1'b1;
                acc       <= '0;
                held      <= '0;
            end
        end
    end

endmodule

// File: rtl/stride_trace_compressor.sv
module stride_trace_compressor
    import stc_pkg::*;
#(
    parameter int PC_W       = STC_PC_W,
    parameter int ADDR_W     = STC_ADDR_W,
    parameter int IDX_W      = STC_IDX_W,
    parameter int IDX_LSB    = STC_IDX_LSB,
    parameter int STRIDE_W   = STC_STRIDE_W,
    parameter int FIFO_DEPTH = STC_FIFO_DEPTH,
    parameter int BYTE_W     = STC_BYTE_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    output logic                         in_ready,
    input  logic [PC_W-1:0]              in_pc,
    input  logic [ADDR_W-1:0]            in_addr,
    input  logic                         flush,
    output logic                         bt_valid,
    input  logic                         bt_ready,
    output logic [BYTE_W-1:0]            bt_byte,
    output logic [$clog2(BYTE_W+1)-1:0]  bt_bits,
    output logic                         ms_valid,
    input  logic                         ms_ready,
    output logic [ADDR_W-1:0]            ms_addr
);
    localparam int DEPTH   = 1 << IDX_W;
    localparam int ENTRY_W = ADDR_W + STRIDE_W;
    localparam int PAIR_W  = PC_W + ADDR_W;
    localparam int EXT_W   = ADDR_W - STRIDE_W;

    stc_state_e state, state_nx;

    logic              fifo_empty, fifo_full, fifo_pop;
    logic [PAIR_W-1:0] fifo_head;
    logic [PC_W-1:0]   head_pc;
    logic [ADDR_W-1:0] head_addr;

    logic [IDX_W-1:0]   clr_idx;
    logic [IDX_W-1:0]   cur_idx;
    logic [ADDR_W-1:0]  cur_addr;
    logic               flush_pend;
    logic               flush_clr;
    logic               flush_en;

    logic               tbl_wr_en, tbl_rd_en;
    logic [IDX_W-1:0]   tbl_wr_idx, tbl_rd_idx;
    logic [ENTRY_W-1:0] tbl_wr_data, tbl_rd_data;
    logic [ADDR_W-1:0]  rd_last;
    logic [STRIDE_W-1:0] rd_stride;
    logic [ADDR_W-1:0]  cand;
    logic [ADDR_W-1:0]  stride_ext;
    logic               hit;
    logic               bit_en;
    logic               miss_load;
    logic               clearing;

    assign head_pc   = fifo_head[PAIR_W-1 -: PC_W];
    assign head_addr = fifo_head[ADDR_W-1:0];
    assign clearing  = (state == ST_CLEAR);
    assign in_ready  = !clearing && !fifo_full && bt_ready && ms_ready;

    stc_fifo #(.W(PAIR_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (in_valid && in_ready),
        .push_data ({in_pc, in_addr}),
        .pop       (fifo_pop),
        .head      (fifo_head),
        .empty     (fifo_empty),
        .full      (fifo_full)
    );

    stc_stride_table #(.IDX_W(IDX_W), .ENTRY_W(ENTRY_W)) u_table (
        .clk     (clk),
        .wr_en   (tbl_wr_en),
        .wr_idx  (tbl_wr_idx),
        .wr_data (tbl_wr_data),
        .rd_en   (tbl_rd_en),
        .rd_idx  (tbl_rd_idx),
        .rd_data (tbl_rd_data)
    );

    stc_bit_packer #(.BYTE_W(BYTE_W)) u_packer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .bit_val   (hit),
        .flush_en  (flush_en),
        .out_ready (bt_ready),
        .out_valid (bt_valid),
        .out_byte  (bt_byte),
        .out_bits  (bt_bits)
    );

    // stride evaluation on the slot read during accept
    assign tbl_rd_idx = head_pc[IDX_LSB +: IDX_W];
    assign rd_last    = tbl_rd_data[ENTRY_W-1 -: ADDR_W];
    assign rd_stride  = tbl_rd_data[STRIDE_W-1:0];
    assign cand       = cur_addr - rd_last;
    assign stride_ext = {{EXT_W{rd_stride[STRIDE_W-1]}}, rd_stride};
    assign hit        = (cand == stride_ext);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_CLEAR;
        end else begin
            state <= state_nx;
        end
    end

    // next state and control outputs
    always_comb begin
        state_nx    = state;
        fifo_pop    = 1'b0;
        tbl_rd_en   = 1'b0;
        tbl_wr_en   = 1'b0;
        tbl_wr_idx  = cur_idx;
        tbl_wr_data = '0;
        bit_en      = 1'b0;
        miss_load   = 1'b0;
        flush_en    = 1'b0;
        flush_clr   = 1'b0;
        unique case (state)
            ST_CLEAR: begin
                tbl_wr_en  = 1'b1;
                tbl_wr_idx = clr_idx;
                if (clr_idx == IDX_W'(DEPTH - 1)) begin
                    state_nx = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (flush_pend) begin
                    if (!bt_valid) begin
                        flush_en  = 1'b1;
                        flush_clr = 1'b1;
                    end
                end else if (!fifo_empty && !bt_valid && !ms_valid) begin
                    fifo_pop  = 1'b1;
                    tbl_rd_en = 1'b1;
                    state_nx  = ST_COMPARE;
                end
            end
            ST_COMPARE: begin
                tbl_wr_en   = 1'b1;
                tbl_wr_data = {cur_addr, hit ? rd_stride : cand[STRIDE_W-1:0]};
                bit_en      = 1'b1;
                miss_load   = !hit;
                state_nx    = ST_IDLE;
            end
            default: begin
                state_nx = ST_CLEAR;
            end
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clr_idx    <= '0;
            cur_idx    <= '0;
            cur_addr   <= '0;
            flush_pend <= 1'b0;
            ms_valid   <= 1'b0;
            ms_addr    <= '0;
        end else begin
            if (clearing) begin
                clr_idx <= clr_idx + 1'b1;
            end
            if (fifo_pop) begin
                cur_idx  <= tbl_rd_idx;
                cur_addr <= head_addr;
            end
            if (flush) begin
                flush_pend <= 1'b1;
            end else if (flush_clr) begin
                flush_pend <= 1'b0;
            end
            if (ms_valid && ms_ready) begin
                ms_valid <= 1'b0;
            end
            if (miss_load) begin
                ms_valid <= 1'b1;
                ms_addr  <= cur_addr;
            end
        end
    end

endmodule

// File: rtl/stc_checker.sv
module stc_checker #(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 32
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         in_ready,
    input logic                         clearing,
    input logic                         bt_valid,
    input logic                         bt_ready,
    input logic [BYTE_W-1:0]            bt_byte,
    input logic [$clog2(BYTE_W+1)-1:0]  bt_bits,
    input logic                         ms_valid,
    input logic                         ms_ready,
    input logic [ADDR_W-1:0]            ms_addr
);
    // R1
    clear_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clearing |-> (!in_ready && !bt_valid && !ms_valid));

    // R9
    backpressure_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bt_ready || !ms_ready) |-> !in_ready);

    // R9
    byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bt_valid && !bt_ready) |=> (bt_valid && $stable(bt_byte) && $stable(bt_bits)));

    // R9
    miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ms_valid && !ms_ready) |=> (ms_valid && $stable(ms_addr)));

    // R7
    byte_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bt_valid |-> ((bt_bits != '0) && (32'(bt_bits) <= BYTE_W)));

endmodule

bind stride_trace_compressor stc_checker #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_ready (in_ready),
    .clearing (clearing),
    .bt_valid (bt_valid),
    .bt_ready (bt_ready),
    .bt_byte  (bt_byte),
    .bt_bits  (bt_bits),
    .ms_valid (ms_valid),
    .ms_ready (ms_ready),
    .ms_addr  (ms_addr)
);

// File: tb/sim_stride_trace_compressor.sv
`timescale 1ns/1ps
module sim_stride_trace_compressor;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_pc = '0;
    logic [31:0] in_addr = '0;
    logic        in_flush = 1'b0;
    logic        bt_valid;
    logic        bt_ready = 1'b1;
    logic [7:0]  bt_byte;
    logic [3:0]  bt_bits;
    logic        ms_valid;
    logic        ms_ready = 1'b1;
    logic [31:0] ms_addr;

    always #5 clk = ~clk;

    stride_trace_compressor u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_pc(in_pc), .in_addr(in_addr),
        .flush(in_flush),
        .bt_valid(bt_valid), .bt_ready(bt_ready), .bt_byte(bt_byte), .bt_bits(bt_bits),
        .ms_valid(ms_valid), .ms_ready(ms_ready), .ms_addr(ms_addr)
    );

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    bp_en = 1'b0;
    bit    done = 1'b0;
    int    bytes_seen = 0;
    int    misses_seen = 0;

    // behavioural reference: per-slot last address and stride, bit accumulator, expected queues
    logic [31:0] m_last [1024];
    logic [7:0]  m_stride [1024];
    logic [7:0]  m_acc = '0;
    int          m_n = 0;
    logic [11:0] exp_bt_q [$];
    logic [31:0] exp_ms_q [$];

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_flush();
        if (m_n > 0) begin
            exp_bt_q.push_back({4'(m_n), m_acc});
            m_acc = '0;
            m_n = 0;
        end
    endtask

    task automatic model_pair(input logic [31:0] pc, input logic [31:0] a);
        int          idx;
        logic [31:0] cand;
        logic [31:0] ext;
        bit          b;
        idx  = int'(pc[11:2]);
        cand = a - m_last[idx];
        ext  = {{24{m_stride[idx][7]}}, m_stride[idx]};
        b    = (cand == ext);
        if (!b) begin
            exp_ms_q.push_back(a);
            m_stride[idx] = cand[7:0];
        end
        m_last[idx] = a;
        m_acc[m_n] = b;
        m_n++;
        if (m_n == 8) begin
            exp_bt_q.push_back({4'd8, m_acc});
            m_acc = '0;
            m_n = 0;
        end
    endtask

    // monitor, compared every clock at the falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (in_flush) model_flush();
            if (in_valid && in_ready) model_pair(in_pc, in_addr);
            if (bt_valid && bt_ready) begin
                logic [11:0] e;
                bytes_seen++;
                if (exp_bt_q.size() == 0) begin
                    check(1'b0, {cur_req, " R7 unexpected byte"}, {20'd0, bt_bits, bt_byte}, 32'hFFF);
                end else begin
                    e = exp_bt_q.pop_front();
                    check({bt_bits, bt_byte} == e, {cur_req, " R7 byte"}, {20'd0, bt_bits, bt_byte}, {20'd0, e});
                end
            end
            if (ms_valid && ms_ready) begin
                logic [31:0] e;
                misses_seen++;
                if (exp_ms_q.size() == 0) begin
                    check(1'b0, {cur_req, " R4 unexpected miss word"}, ms_addr, 32'hFFFFFFFF);
                end else begin
                    e = exp_ms_q.pop_front();
                    check(ms_addr == e, {cur_req, " R4 miss word"}, ms_addr, e);
                end
            end
            if (!bt_ready || !ms_ready) begin
                check(!in_ready, "R9 in_ready with output stalled", {31'd0, in_ready}, 32'd0);
            end
        end
    end

    // output backpressure pattern
    logic [31:0] bp_lf = 32'h1234_5679;
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (bp_en) begin
                bp_lf    = {bp_lf[30:0], bp_lf[31] ^ bp_lf[21] ^ bp_lf[1] ^ bp_lf[0]};
                bt_ready = bp_lf[0] | bp_lf[3];
                ms_ready = bp_lf[5] | bp_lf[9];
            end else begin
                bt_ready = 1'b1;
                ms_ready = 1'b1;
            end
        end
    end

    task automatic push(input logic [31:0] pc, input logic [31:0] a, input bit fl);
        bit acc;
        in_pc    = pc;
        in_addr  = a;
        in_valid = 1'b1;
        in_flush = fl;
        forever begin
            @(negedge clk);
            acc = in_ready;
            @(posedge clk);
            #1;
            in_flush = 1'b0;
            if (acc) break;
        end
        in_valid = 1'b0;
    endtask

    task automatic quiet();
        bp_en = 1'b0;
        repeat (40) @(posedge clk);
        #1;
    endtask

    task automatic flush_now();
        in_flush = 1'b1;
        @(posedge clk);
        #1;
        in_flush = 1'b0;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R10 watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    function automatic logic [31:0] xs(input logic [31:0] v);
        logic [31:0] r;
        r = v ^ (v << 13);
        r = r ^ (r >> 17);
        r = r ^ (r << 5);
        return r;
    endfunction

    initial begin
        int clr_cycles;
        logic [31:0] rs;
        logic [31:0] walk [4];
        logic [31:0] step [4];
        for (int i = 0; i < 1024; i++) begin
            m_last[i] = '0;
            m_stride[i] = '0;
        end
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1: outputs idle and input closed while slots are cleared
        @(negedge clk);
        check(!bt_valid, "R1 bt_valid after reset", {31'd0, bt_valid}, 32'd0);
        check(!ms_valid, "R1 ms_valid after reset", {31'd0, ms_valid}, 32'd0);
        check(!in_ready, "R1 in_ready during clear", {31'd0, in_ready}, 32'd0);
        clr_cycles = 1;
        while (!in_ready && clr_cycles < 5000) begin
            @(negedge clk);
            clr_cycles++;
        end
        check(clr_cycles >= 1020 && clr_cycles <= 1030, "R1 clear sweep length", clr_cycles, 1024);
        @(posedge clk);
        #1;

        // R1, R3: a fresh slot at address 0 hits; fresh slot at nonzero address misses (R4)
        cur_req = "R1";
        push(32'h0000_0100, 32'h0000_0000, 1'b0);
        push(32'h0000_0104, 32'h0000_0040, 1'b0);
        quiet();
        flush_now();
        quiet();

        // R3, R6: constant-stride walk
        cur_req = "R3";
        for (int i = 0; i < 12; i++) push(32'h0000_0200, 32'h0000_1000 + 32'(i * 4), 1'b0);
        // negative stride
        for (int i = 0; i < 6; i++) push(32'h0000_0208, 32'h0008_0000 - 32'(i * 8), 1'b0);
        quiet();
        flush_now();
        quiet();

        // R5: stride of +200 truncates to -56 and keeps missing; +127 and -128 fit
        cur_req = "R5";
        for (int i = 0; i < 5; i++) push(32'h0000_0300, 32'h0010_0000 + 32'(i * 200), 1'b0);
        for (int i = 0; i < 4; i++) push(32'h0000_0304, 32'h0020_0000 + 32'(i * 127), 1'b0);
        for (int i = 0; i < 4; i++) push(32'h0000_0308, 32'h0030_0000 - 32'(i * 128), 1'b0);
        quiet();
        flush_now();
        quiet();

        // R2, R6: aliasing instruction addresses share the slot (bits above 11 and below 2 ignored)
        cur_req = "R2";
        push(32'h0000_0400, 32'h0000_5000, 1'b0);
        push(32'h0000_0400, 32'h0000_5010, 1'b0);
        push(32'h7FFF_F400, 32'h0000_5020, 1'b0);
        push(32'h0000_0403, 32'h0000_5030, 1'b0);
        push(32'h0000_1400, 32'h0000_5040, 1'b0);
        push(32'h0000_0404, 32'h0000_5050, 1'b0);
        quiet();
        flush_now();
        quiet();

        // R8: flush with nothing held yields no byte
        cur_req = "R8";
        flush_now();
        quiet();
        check(exp_bt_q.size() == 0 && !bt_valid, "R8 empty flush", {31'd0, bt_valid}, 32'd0);

        // R8: flush in the same cycle as the accepted pair, seven bits held
        for (int i = 0; i < 7; i++) push(32'h0000_0500, 32'h0000_9000 + 32'(i * 4), 1'b0);
        quiet();
        check(m_n == 7, "R8 seven bits held in model", m_n, 7);
        push(32'h0000_0500, 32'h0000_901C, 1'b1);
        quiet();
        flush_now();
        quiet();

        // R7, R8: flush one cycle after the pair that completes a byte
        for (int i = 0; i < 7; i++) push(32'h0000_0504, 32'h0000_A000 + 32'(i * 2), 1'b0);
        quiet();
        push(32'h0000_0504, 32'h0000_A00E, 1'b0);
        flush_now();
        quiet();
        check(m_n == 0, "R7 byte completed before flush", m_n, 0);
        push(32'h0000_0504, 32'h0000_A010, 1'b0);
        quiet();
        flush_now();
        quiet();

        // R9, R10: back-to-back pushes under output backpressure, mixed strides
        cur_req = "R10";
        rs = 32'hC0FF_EE11;
        for (int k = 0; k < 4; k++) begin
            walk[k] = 32'h0100_0000 * 32'(k + 1);
            step[k] = (k == 0) ? 32'd4 : (k == 1) ? 32'd8 : (k == 2) ? 32'hFFFF_FFF0 : 32'd300;
        end
        bp_en = 1'b1;
        for (int i = 0; i < 400; i++) begin
            int k;
            rs = xs(rs);
            k = int'(rs[1:0]);
            if (rs[7:4] == 4'h0) walk[k] = walk[k] + {rs[31:16], 16'd0};
            else walk[k] = walk[k] + step[k];
            push(32'h0000_0600 + 32'(k * 4), walk[k], 1'b0);
        end
        quiet();
        flush_now();
        quiet();

        // R10: everything predicted was delivered
        check(exp_bt_q.size() == 0, "R10 bytes outstanding", exp_bt_q.size(), 0);
        check(exp_ms_q.size() == 0, "R10 miss words outstanding", exp_ms_q.size(), 0);
        check(bytes_seen > 50, "R7 bytes observed", bytes_seen, 51);
        check(misses_seen > 20, "R4 miss words observed", misses_seen, 21);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule